// File: doc/BRIEF.md
# Five-Stage Pipeline Control Tracker

This block follows instructions through a five-stage in-order pipeline: fetch, decode with register read, execute or address calculation, memory access, and writeback. It handles only the bookkeeping for a small load/store machine. It does not compute results. Instead it carries each instruction's identity, its incremented program counter, its destination register number and its control fields through four stage registers. It then reports what the writeback stage would do.

Control is decoded once, in decode, and split into three groups by the stage that consumes them:

- the execute unit select;
- the memory read and write enables;
- the register-write enable.

Each group is dropped from the stage records once its stage has used it.

A build-time parameter chooses between two memory arrangements:

- **Separate memories.** Instruction and data memories are separate, and the pipeline never stalls.
- **Shared memory.** One memory port serves both. A load or store in the memory stage then takes the port from fetch. The front of the pipe holds for one cycle, and a bubble enters the execute stage.

A retire counter lets the surrounding logic measure throughput and count the cycles lost to stalls.

Top module: `pipeTracker`

## Requirements
- R1: While reset is sampled high at a clock edge, the tracker empties all four stage registers, sets the fetch address to 0 and sets the retire count to 0. In the first cycle after reset, stall and wbValid are low.
- R2: Instruction bits [31:30] select the class: 00 no operation, 01 register operation, 10 load, 11 store. In the cycle after an instruction leaves decode, exSel shows bit 0 set for a register operation, bit 1 set for a load or store, and 00 for a no-operation or an empty slot.
- R3: fetchPc starts at 0 and grows by 4 on every cycle without a stall. The fetch address plus 4 is recorded with each fetched instruction and appears on wbPcPlus4 when that instruction reaches writeback.
- R4: Without stalls, the k-th instruction fetched after reset (k = 1, 2, ...) is in writeback in cycle k+4. A run of I instructions therefore finishes in I+4 cycles.
- R5: In writeback, wbReg equals bits [4:0] of the instruction occupying writeback, and wbInstr equals that instruction's word. Both are carried from decode, not taken from the instruction currently being decoded.
- R6: wbEn is high only when writeback holds a valid register operation or load whose destination is not register 0.
- R7: In shared mode, stall is high in exactly the cycles in which the memory stage holds a valid load or store.
- R8: During a stall, fetchPc and the decode-stage instruction hold, and an empty slot enters execute. Every instruction still in decode or fetch reaches writeback one cycle later for each such stall.
- R9: In separate-memory mode, stall is never raised and timing follows R4.
- R10: retireCount grows by exactly one at the end of every cycle in which writeback holds a valid instruction.
- R11: A fetch slot presented with instrValid low never shows up on wbValid or wbEn, and never changes retireCount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instrWord | input | XLEN | Instruction word read at fetchPc |
| instrValid | input | 1 | instrWord holds a real instruction |
| fetchPc | output | PC_W | Current fetch address |
| stall | output | 1 | Front of pipe held this cycle, bubble entering execute |
| exSel | output | 2 | Execute-stage unit select: bit 0 register op, bit 1 address calc |
| wbValid | output | 1 | Writeback stage holds an instruction |
| wbEn | output | 1 | Register-file write enable |
| wbReg | output | REG_W | Register-file write address |
| wbInstr | output | XLEN | Instruction word in writeback |
| wbPcPlus4 | output | PC_W | Incremented fetch address of the instruction in writeback |
| retireCount | output | CNT_W | Number of instructions that have left writeback |

## Verification
- **stall** is combinational from the execute/memory record, so it is due in the same cycle the load or store sits in the memory stage.
- **fetchPc** changes at the edge that ends a cycle without a stall.
- **exSel** is due one cycle after the decode cycle.
- **wbValid, wbEn, wbReg, wbInstr and wbPcPlus4** are due three cycles after decode.
- **retireCount** rises at the edge that ends the writeback cycle.

For each program, the bench first computes each instruction's decode cycle from the stall cycles caused by earlier memory instructions. From that it builds a per-cycle table of expected outputs. It then compares every output half a period after each rising edge, counting cycles from the first cycle after reset.

// File: rtl/pipeTrackerPkg.sv
package pipeTrackerPkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_REG   = 2'b01,
    OP_LOAD  = 2'b10,
    OP_STORE = 2'b11
  } opClass_t;

  // consumed in execute
  typedef struct packed {
    logic useAddr;
    logic useAlu;
  } exCtrl_t;

  // consumed in memory
  typedef struct packed {
    logic rd;
    logic wr;
  } memCtrl_t;

  // consumed in writeback
  typedef struct packed {
    logic regWr;
  } wbCtrl_t;

  // control to datapath strobes
  typedef struct packed {
    logic advanceFront;
    logic bubbleDecode;
  } strobe_t;

endpackage

// File: rtl/pipeTrackerDecode.sv
module pipeTrackerDecode
  import pipeTrackerPkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             slotValid,
  input  logic [1:0]       opBits,
  input  logic [REG_W-1:0] destField,
  output exCtrl_t          exCtrl,
  output memCtrl_t         memCtrl,
  output wbCtrl_t          wbCtrl,
  output logic [REG_W-1:0] dest
);

  opClass_t opClass;

  always_comb begin
    opClass = opClass_t'(opBits);
    exCtrl  = '0;
    memCtrl = '0;
    wbCtrl  = '0;
    if (slotValid) begin
      unique case (opClass)
        OP_REG: begin
          exCtrl.useAlu = 1'b1;
          wbCtrl.regWr  = 1'b1;
        end
        OP_LOAD: begin
          exCtrl.useAddr = 1'b1;
          memCtrl.rd     = 1'b1;
          wbCtrl.regWr   = 1'b1;
        end
        OP_STORE: begin
          exCtrl.useAddr = 1'b1;
          memCtrl.wr     = 1'b1;
        end
        default: ;
      endcase
    end
    dest = slotValid ? destField : '0;
  end

endmodule

// File: rtl/pipeTrackerHazard.sv
module pipeTrackerHazard
  import pipeTrackerPkg::*;
#(
  parameter bit SHARED_MEM = 1'b1
) (
  input  logic    memStageAccess,
  output strobe_t strb,
  output logic    stall
);

  generate
    if (SHARED_MEM) begin : g_sharedPort
      // memory stage owns the single port this cycle
      assign stall = memStageAccess;
    end else begin : g_splitPort
      logic unusedAccess;
      assign unusedAccess = memStageAccess;
      assign stall = 1'b0;
    end
  endgenerate

  always_comb begin
    strb.advanceFront = !stall;
    strb.bubbleDecode = stall;
  end

endmodule

// File: rtl/pipeTrackerDatapath.sv
module pipeTrackerDatapath
  import pipeTrackerPkg::*;
#(
  parameter int XLEN        = 32,
  parameter int PC_W        = 32,
  parameter int REG_W       = 5,
  parameter int CNT_W       = 16,
  parameter int INSTR_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [XLEN-1:0]  instrWord,
  input  logic             instrValid,
  input  strobe_t          strb,
  input  exCtrl_t          decEx,
  input  memCtrl_t         decMem,
  input  wbCtrl_t          decWb,
  input  logic [REG_W-1:0] decDest,
  output logic             decValid,
  output logic [1:0]       decOpBits,
  output logic [REG_W-1:0] decDestField,
  output logic             memStageAccess,
  output logic [PC_W-1:0]  fetchPc,
  output logic [1:0]       exSel,
  output logic             wbValid,
  output logic             wbEn,
  output logic [REG_W-1:0] wbReg,
  output logic [XLEN-1:0]  wbInstr,
  output logic [PC_W-1:0]  wbPcPlus4,
  output logic [CNT_W-1:0] retireCount
);

  localparam int OP_MSB = XLEN - 1;
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(INSTR_BYTES);

  typedef struct packed {
    logic            valid;
    logic [XLEN-1:0] instr;
    logic [PC_W-1:0] pcPlus4;
  } ifIdRec_t;

  typedef struct packed {
    logic             valid;
    logic [XLEN-1:0]  instr;
    logic [PC_W-1:0]  pcPlus4;
    logic [REG_W-1:0] dest;
    exCtrl_t          ex;
    memCtrl_t         mem;
    wbCtrl_t          wb;
  } idExRec_t;

  typedef struct packed {
    logic             valid;
    logic [XLEN-1:0]  instr;
    logic [PC_W-1:0]  pcPlus4;
    logic [REG_W-1:0] dest;
    memCtrl_t         mem;
    wbCtrl_t          wb;
  } exMemRec_t;

  typedef struct packed {
    logic             valid;
    logic [XLEN-1:0]  instr;
    logic [PC_W-1:0]  pcPlus4;
    logic [REG_W-1:0] dest;
    wbCtrl_t          wb;
  } memWbRec_t;

  logic [PC_W-1:0]  pcQ;
  logic [PC_W-1:0]  pcPlusStep;
  logic [CNT_W-1:0] retireQ;
  ifIdRec_t  ifIdQ,  ifIdNext;
  idExRec_t  idExQ,  idExNext;
  exMemRec_t exMemQ, exMemNext;
  memWbRec_t memWbQ, memWbNext;

  assign pcPlusStep = pcQ + PC_STEP;

  // field split for the decoder
  assign decValid     = ifIdQ.valid;
  assign decOpBits    = ifIdQ.instr[OP_MSB -: 2];
  assign decDestField = ifIdQ.instr[REG_W-1:0];

  always_comb begin
    ifIdNext.valid   = instrValid;
    ifIdNext.instr   = instrWord;
    ifIdNext.pcPlus4 = pcPlusStep;

    idExNext.valid   = ifIdQ.valid;
    idExNext.instr   = ifIdQ.instr;
    idExNext.pcPlus4 = ifIdQ.pcPlus4;
    idExNext.dest    = decDest;
    idExNext.ex      = decEx;
    idExNext.mem     = decMem;
    idExNext.wb      = decWb;

    // execute group is shed here
    exMemNext.valid   = idExQ.valid;
    exMemNext.instr   = idExQ.instr;
    exMemNext.pcPlus4 = idExQ.pcPlus4;
    exMemNext.dest    = idExQ.dest;
    exMemNext.mem     = idExQ.mem;
    exMemNext.wb      = idExQ.wb;

    // memory group is shed here
    memWbNext.valid   = exMemQ.valid;
    memWbNext.instr   = exMemQ.instr;
    memWbNext.pcPlus4 = exMemQ.pcPlus4;
    memWbNext.dest    = exMemQ.dest;
    memWbNext.wb      = exMemQ.wb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ     <= '0;
      ifIdQ   <= '0;
      idExQ   <= '0;
      exMemQ  <= '0;
      memWbQ  <= '0;
      retireQ <= '0;
    end else begin
      if (strb.advanceFront) begin
        pcQ   <= pcPlusStep;
        ifIdQ <= ifIdNext;
      end
      if (strb.bubbleDecode) begin
        idExQ <= '0;
      end else begin
        idExQ <= idExNext;
      end
      exMemQ <= exMemNext;
      memWbQ <= memWbNext;
      if (memWbQ.valid) begin
        retireQ <= retireQ + CNT_W'(1);
      end
    end
  end

  assign memStageAccess = exMemQ.valid && (exMemQ.mem.rd || exMemQ.mem.wr);
  assign fetchPc        = pcQ;
  assign exSel          = idExQ.valid ? {idExQ.ex.useAddr, idExQ.ex.useAlu} : 2'b00;
  assign wbValid        = memWbQ.valid;
  assign wbEn           = memWbQ.valid && memWbQ.wb.regWr && (memWbQ.dest != '0);
  assign wbReg          = memWbQ.dest;
  assign wbInstr        = memWbQ.instr;
  assign wbPcPlus4      = memWbQ.pcPlus4;
  assign retireCount    = retireQ;

endmodule

// File: rtl/pipeTracker.sv
module pipeTracker
  import pipeTrackerPkg::*;
#(
  parameter int XLEN       = 32,
  parameter int PC_W       = 32,
  parameter int REG_W      = 5,
  parameter int CNT_W      = 16,
  parameter bit SHARED_MEM = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [XLEN-1:0]  instrWord,
  input  logic             instrValid,
  output logic [PC_W-1:0]  fetchPc,
  output logic             stall,
  output logic [1:0]       exSel,
  output logic             wbValid,
  output logic             wbEn,
  output logic [REG_W-1:0] wbReg,
  output logic [XLEN-1:0]  wbInstr,
  output logic [PC_W-1:0]  wbPcPlus4,
  output logic [CNT_W-1:0] retireCount
);

  strobe_t          strb;
  exCtrl_t          decEx;
  memCtrl_t         decMem;
  wbCtrl_t          decWb;
  logic [REG_W-1:0] decDest;
  logic             decValid;
  logic [1:0]       decOpBits;
  logic [REG_W-1:0] decDestField;
  logic             memStageAccess;

  pipeTrackerDecode #(.REG_W(REG_W)) u_decode (
    .slotValid (decValid),
    .opBits    (decOpBits),
    .destField (decDestField),
    .exCtrl    (decEx),
    .memCtrl   (decMem),
    .wbCtrl    (decWb),
    .dest      (decDest)
  );

  pipeTrackerHazard #(.SHARED_MEM(SHARED_MEM)) u_hazard (
    .memStageAccess (memStageAccess),
    .strb           (strb),
    .stall          (stall)
  );

  pipeTrackerDatapath #(
    .XLEN  (XLEN),
    .PC_W  (PC_W),
    .REG_W (REG_W),
    .CNT_W (CNT_W)
  ) u_datapath (
    .clk            (clk),
    .rst            (rst),
    .instrWord      (instrWord),
    .instrValid     (instrValid),
    .strb           (strb),
    .decEx          (decEx),
    .decMem         (decMem),
    .decWb          (decWb),
    .decDest        (decDest),
    .decValid       (decValid),
    .decOpBits      (decOpBits),
    .decDestField   (decDestField),
    .memStageAccess (memStageAccess),
    .fetchPc        (fetchPc),
    .exSel          (exSel),
    .wbValid        (wbValid),
    .wbEn           (wbEn),
    .wbReg          (wbReg),
    .wbInstr        (wbInstr),
    .wbPcPlus4      (wbPcPlus4),
    .retireCount    (retireCount)
  );

endmodule

// File: rtl/pipeTrackerChecker.sv
module pipeTrackerChecker #(
  parameter int PC_W       = 32,
  parameter int REG_W      = 5,
  parameter int CNT_W      = 16,
  parameter bit SHARED_MEM = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [PC_W-1:0]  fetchPc,
  input logic             stall,
  input logic             wbValid,
  input logic             wbEn,
  input logic [REG_W-1:0] wbReg,
  input logic [CNT_W-1:0] retireCount
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (fetchPc == '0) && (retireCount == '0) && !wbValid);

  a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
    !stall |=> fetchPc == PC_W'($past(fetchPc) + PC_W'(4)));

  a_r8_pc_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(fetchPc));

  a_r8_bubble_gap: assert property (@(posedge clk) disable iff (rst)
    stall |-> ##2 !stall);

  a_r6_no_reg0: assert property (@(posedge clk) disable iff (rst)
    wbEn |-> (wbValid && (wbReg != '0)));

  a_r10_retire_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> retireCount == CNT_W'($past(retireCount) + CNT_W'($past(wbValid))));

  generate
    if (!SHARED_MEM) begin : g_splitChk
      a_r9_never_stall: assert property (@(posedge clk) disable iff (rst)
        !stall);
    end
  endgenerate

endmodule

bind pipeTracker pipeTrackerChecker #(
  .PC_W       (PC_W),
  .REG_W      (REG_W),
  .CNT_W      (CNT_W),
  .SHARED_MEM (SHARED_MEM)
) u_pipeChk (
  .clk         (clk),
  .rst         (rst),
  .fetchPc     (fetchPc),
  .stall       (stall),
  .wbValid     (wbValid),
  .wbEn        (wbEn),
  .wbReg       (wbReg),
  .retireCount (retireCount)
);

// File: tb/test_pipeTracker.sv
`timescale 1ns/1ps
module test_pipeTracker;

  localparam int XLEN  = 32;
  localparam int PC_W  = 32;
  localparam int REG_W = 5;
  localparam int CNT_W = 16;
  localparam int MAXI  = 16;
  localparam int MAXC  = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [XLEN-1:0] prog [MAXI];
  int progLen = 0;
  int curPat  = 0;

  // shared-memory instance signals
  logic [XLEN-1:0]  instrWordSh;
  logic             instrValidSh;
  logic [PC_W-1:0]  fetchPcSh;
  logic             stallSh;
  logic [1:0]       exSelSh;
  logic             wbValidSh, wbEnSh;
  logic [REG_W-1:0] wbRegSh;
  logic [XLEN-1:0]  wbInstrSh;
  logic [PC_W-1:0]  wbPcPlus4Sh;
  logic [CNT_W-1:0] retireSh;

  // split-memory instance signals
  logic [XLEN-1:0]  instrWordSp;
  logic             instrValidSp;
  logic [PC_W-1:0]  fetchPcSp;
  logic             stallSp;
  logic [1:0]       exSelSp;
  logic             wbValidSp, wbEnSp;
  logic [REG_W-1:0] wbRegSp;
  logic [XLEN-1:0]  wbInstrSp;
  logic [PC_W-1:0]  wbPcPlus4Sp;
  logic [CNT_W-1:0] retireSp;

  function automatic bit fetchOk(input logic [PC_W-1:0] pc);
    return (pc[1:0] == 2'b00) && (int'(pc >> 2) < progLen);
  endfunction

  always_comb begin
    instrValidSh = fetchOk(fetchPcSh);
    instrWordSh  = instrValidSh ? prog[int'(fetchPcSh >> 2)] : '0;
    instrValidSp = fetchOk(fetchPcSp);
    instrWordSp  = instrValidSp ? prog[int'(fetchPcSp >> 2)] : '0;
  end

  pipeTracker #(.SHARED_MEM(1'b1)) i_pipeTracker (
    .clk(clk), .rst(rst), .instrWord(instrWordSh), .instrValid(instrValidSh),
    .fetchPc(fetchPcSh), .stall(stallSh), .exSel(exSelSh), .wbValid(wbValidSh),
    .wbEn(wbEnSh), .wbReg(wbRegSh), .wbInstr(wbInstrSh), .wbPcPlus4(wbPcPlus4Sh),
    .retireCount(retireSh)
  );

  pipeTracker #(.SHARED_MEM(1'b0)) i_pipeTrackerSplit (
    .clk(clk), .rst(rst), .instrWord(instrWordSp), .instrValid(instrValidSp),
    .fetchPc(fetchPcSp), .stall(stallSp), .exSel(exSelSp), .wbValid(wbValidSp),
    .wbEn(wbEnSp), .wbReg(wbRegSp), .wbInstr(wbInstrSp), .wbPcPlus4(wbPcPlus4Sp),
    .retireCount(retireSp)
  );

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s pattern=%0d len=%0d actual=%0d expected=%0d",
               req, what, curPat, progLen, act, exp);
    end
  endtask

  function automatic int opOf(input int p, input int k);
    case (p)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return (k % 3 == 0) ? 2 : 1;
      4: return (k % 2 == 1) ? 3 : 0;
      default: return ((k * k * 5 + k * 3 + p) >> 1) % 4;
    endcase
  endfunction

  function automatic int destOf(input int p, input int k);
    return (k * 7 + p * 3) % 32;
  endfunction

  // expected tables, [0] shared, [1] split
  int expWbK  [2][MAXC];
  int expExK  [2][MAXC];
  int expPc   [2][MAXC];
  int expRet  [2][MAXC];
  bit expStall[2][MAXC];
  int lastWb  [2];

  task automatic buildModel(input int m);
    int fC, dC, nonStall;
    for (int c = 0; c < MAXC; c++) begin
      expWbK[m][c] = 0; expExK[m][c] = 0; expStall[m][c] = 1'b0;
      expPc[m][c] = 0; expRet[m][c] = 0;
    end
    fC = 1;
    dC = 1;
    lastWb[m] = 0;
    for (int k = 1; k <= progLen; k++) begin
      if (k > 1) fC = dC;
      dC = fC + 1;
      while (expStall[m][dC]) dC++;
      expExK[m][dC + 1] = k;
      expWbK[m][dC + 3] = k;
      lastWb[m] = dC + 3;
      if (m == 0 && opOf(curPat, k) >= 2) expStall[m][dC + 2] = 1'b1;
    end
    nonStall = 0;
    for (int c = 1; c < MAXC; c++) begin
      expPc[m][c] = 4 * nonStall;
      if (!expStall[m][c]) nonStall++;
      expRet[m][c] = (c > 1) ? expRet[m][c-1] + ((expWbK[m][c-1] != 0) ? 1 : 0) : 0;
    end
  endtask

  task automatic checkCycle(input int m, input int c);
    int k, op, d, eSel, expEn;
    int aStall, aPc, aEx, aVal, aEn, aReg, aInstr, aPc4, aRet;
    if (m == 0) begin
      aStall = int'(stallSh); aPc = int'(fetchPcSh); aEx = int'(exSelSh);
      aVal = int'(wbValidSh); aEn = int'(wbEnSh); aReg = int'(wbRegSh);
      aInstr = int'(wbInstrSh); aPc4 = int'(wbPcPlus4Sh); aRet = int'(retireSh);
    end else begin
      aStall = int'(stallSp); aPc = int'(fetchPcSp); aEx = int'(exSelSp);
      aVal = int'(wbValidSp); aEn = int'(wbEnSp); aReg = int'(wbRegSp);
      aInstr = int'(wbInstrSp); aPc4 = int'(wbPcPlus4Sp); aRet = int'(retireSp);
    end
    check(m == 0 ? "R7" : "R9", "stall", aStall, int'(expStall[m][c]));
    check(m == 0 ? "R8" : "R3", "fetchPc", aPc, expPc[m][c]);
    k = expExK[m][c];
    eSel = 0;
    if (k != 0) begin
      op = opOf(curPat, k);
      eSel = (op == 1) ? 1 : ((op >= 2) ? 2 : 0);
    end
    check("R2", "exSel", aEx, eSel);
    k = expWbK[m][c];
    check(m == 0 ? "R8" : "R4", "wbValid", aVal, (k != 0) ? 1 : 0);
    expEn = 0;
    if (k != 0) begin
      op = opOf(curPat, k);
      d  = destOf(curPat, k);
      expEn = ((op == 1 || op == 2) && d != 0) ? 1 : 0;
      check("R5", "wbReg", aReg, d);
      check("R5", "wbInstr", aInstr, int'(prog[k-1]));
      check("R3", "wbPcPlus4", aPc4, 4 * k);
    end
    check("R6", "wbEn", aEn, expEn);
    if (c > lastWb[m]) begin
      check("R11", "retire after program", aRet, progLen);
      check("R11", "no wb on empty slot", aVal, 0);
    end else begin
      check("R10", "retireCount", aRet, expRet[m][c]);
    end
  endtask

  task automatic runProgram(input int p, input int len);
    int nCyc;
    curPat  = p;
    progLen = len;
    for (int k = 1; k <= MAXI; k++) begin
      prog[k-1] = {2'(opOf(p, k)), 25'(k * 1103 + p), 5'(destOf(p, k))};
    end
    buildModel(0);
    buildModel(1);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // cycle 1 after reset: empty pipe
    check("R1", "reset fetchPc", int'(fetchPcSh), 0);
    check("R1", "reset retire", int'(retireSh), 0);
    check("R1", "reset wbValid", int'(wbValidSh), 0);
    check("R1", "reset stall", int'(stallSh), 0);
    nCyc = 2 * len + 8;
    for (int c = 1; c <= nCyc; c++) begin
      checkCycle(0, c);
      checkCycle(1, c);
      @(negedge clk);
      #1;
    end
    // no-stall total: last instruction done by cycle len+4
    check("R4", "split total cycles", lastWb[1], len + 4);
  endtask

  initial begin
    for (int p = 0; p < 7; p++) begin
      runProgram(p, 1);
      runProgram(p, 2);
      runProgram(p, 5);
      runProgram(p, 9);
      runProgram(p, 16);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule